// File: doc/BRIEF.md
# Seven-to-one four-lane pixel serializer

This block turns a stream of 28-bit parallel pixel words into four serial lanes and one forwarded clock lane for a low-swing display link. It runs entirely on a bit clock at seven times the pixel rate. The pixel clock comes in as a plain level input, and the block samples it on the bit clock. An edge detector turns the selected pixel-clock transition into a capture strobe. The captured word goes into a holding register. At the start of the next frame the holding register transfers into four 7-bit shift registers. Each shift register then sends its seven bits, one per bit-clock cycle, in a fixed scattered order of the input bits.

A free-running modulo-7 slot counter divides time into frames. A frame begins only when the counter wraps from slot 6 to slot 0. A word captured part-way through a frame therefore never disturbs bits already on the lanes. The forwarded clock has the pixel rate. It is high for slots 0 to 3 and low for slots 4 to 6, so the receiver can find slot 0 from its rising edge.

The active-low shutdown clears everything at once. A small state machine keeps the lanes silent after release until a whole captured word can start at slot 0. Its states are ST_WAIT_WORD (no word captured yet), ST_ARMED (a word is held and the block waits for the wrap) and ST_STREAM (frames are being sent). Its transitions are T_CAPTURE_FIRST (ST_WAIT_WORD to ST_ARMED on the first capture strobe), T_FRAME_START (ST_ARMED to ST_STREAM on the slot wrap) and T_KEEP_STREAM (ST_STREAM holds until shutdown). Shutdown returns the machine to ST_WAIT_WORD from any state.

Top module: `sertx_pixel_serializer`

## Requirements
- R1: With rise_sel = 1 the word on pix_word is captured on a 0-to-1 change of pix_clk; with rise_sel = 0 it is captured on a 1-to-0 change. The change is seen on the first bit-clock edge at which the new pix_clk level is present, and the word is sampled on that same edge. The first bit-clock edge after shutdown release never captures.
- R2: lane_out[0] sends, in time order from slot 0 to slot 6, the word bits 7, 6, 4, 3, 2, 1, 0.
- R3: lane_out[1] sends, in time order from slot 0 to slot 6, the word bits 18, 15, 14, 13, 12, 9, 8.
- R4: lane_out[2] sends, in time order from slot 0 to slot 6, the word bits 26, 25, 24, 22, 21, 20, 19.
- R5: lane_out[3] sends, in time order from slot 0 to slot 6, the word bits 23, 17, 16, 11, 10, 5, 27.
- R6: While streaming, fwd_clk is 1 in slots 0, 1, 2 and 3 and 0 in slots 4, 5 and 6. Its rising edge comes in the same bit-clock cycle as the first bit of a frame.
- R7: A frame starts only when the slot counter wraps from 6 to 0, and it carries the whole word held at that moment. Each captured word is sent exactly once, in capture order. If no new word has been captured since the last wrap, the held word is sent again.
- R8: While shdn_n is 0, every register is cleared at once, without waiting for a clock edge, and lane_out and fwd_clk are 0.
- R9: After shdn_n returns to 1, lane_out and fwd_clk stay 0 until the first captured word begins at slot 0. The first frame sent is that word, complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| shdn_n | input | 1 | Active-low shutdown and asynchronous clear |
| pix_clk | input | 1 | Pixel clock level, sampled on clk |
| rise_sel | input | 1 | 1: capture on pixel-clock rise; 0: capture on fall |
| pix_word | input | 28 | Parallel pixel word, bit 0 to bit 27 |
| lane_out | output | 4 | Serial data lanes, one bit per slot |
| fwd_clk | output | 1 | Forwarded pixel-rate clock, high in slots 0 to 3 |

## Verification
The hardest situation to reach from the ports is a shutdown that lands in the middle of a frame, followed by a release at a slot phase the bench does not control. The stimulus asserts shdn_n a few cycles into a running frame and then keeps pix_clk idle for many cycles, so the quiet period after release can be observed. Only then does it start a fresh word stream, and the first recovered frame must be the first new word. The capture edge is proven by putting the complement of each word on the input between the two pixel-clock edges, so a block that captures on the wrong edge recovers inverted words. A walking-one sequence drives each of the 28 bit positions alone, which pins every entry of the lane scatter.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Frame geometry: slots per pixel period and number of data lanes.
    localparam int SLOTS      = 7;
    localparam int LANES      = 4;
    localparam int WORD_W     = LANES * SLOTS;
    localparam int CNT_W      = $clog2(SLOTS);
    // Number of leading slots in which the forwarded clock is high.
    localparam int HIGH_SLOTS = 4;

    // Source bit of the input word for each lane and slot, in transmit order.
    localparam int SRC_MAP [LANES][SLOTS] = '{
        '{ 7,  6,  4,  3,  2,  1,  0},
        '{18, 15, 14, 13, 12,  9,  8},
        '{26, 25, 24, 22, 21, 20, 19},
        '{23, 17, 16, 11, 10,  5, 27}
    };

    typedef enum logic [1:0] {
        ST_WAIT_WORD = 2'd0,
        ST_ARMED     = 2'd1,
        ST_STREAM    = 2'd2
    } tx_state_t;

endpackage

// File: rtl/sertx_edge_detect.sv
module sertx_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pix,
    input  logic rise_sel,
    output logic strobe
);

    logic pix_q;
    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q    <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            pix_q    <= pix;
            primed_q <= 1'b1;
        end
    end

    // No edge is reported until one pixel-clock sample has been taken.
    always_comb begin
        strobe = 1'b0;
        if (primed_q) begin
            if (rise_sel) begin
                strobe = pix & ~pix_q;
            end else begin
                strobe = ~pix & pix_q;
            end
        end
    end

endmodule

// File: rtl/sertx_slot_counter.sv
module sertx_slot_counter #(
    parameter int  SLOTS = 7,
    localparam int CW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] slot_q,
    output logic [CW-1:0] slot_next,
    output logic          wrap
);

    assign wrap      = (slot_q == CW'(SLOTS - 1));
    assign slot_next = wrap ? '0 : slot_q + CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_next;
        end
    end

endmodule

// File: rtl/sertx_lane_shifter.sv
module sertx_lane_shifter #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SLOTS-1:0] par,
    output logic             ser
);

    logic [SLOTS-1:0] sr_q;

    // The top bit leaves first; zeros follow once the frame is spent.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= par;
        end else begin
            sr_q <= {sr_q[SLOTS-2:0], 1'b0};
        end
    end

    assign ser = sr_q[SLOTS-1];

endmodule

// File: rtl/sertx_pixel_serializer.sv
module sertx_pixel_serializer
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              shdn_n,
    input  logic              pix_clk,
    input  logic              rise_sel,
    input  logic [WORD_W-1:0] pix_word,
    output logic [LANES-1:0]  lane_out,
    output logic              fwd_clk
);

    tx_state_t         state_q;
    tx_state_t         state_d;
    logic [CNT_W-1:0]  slot_q;
    logic [CNT_W-1:0]  slot_next;
    logic              slot_wrap;
    logic              cap_stb;
    logic [WORD_W-1:0] hold_q;
    logic              frame_load;
    logic              fclk_d;

    sertx_edge_detect i_edge (
        .clk      (clk),
        .rst_n    (shdn_n),
        .pix      (pix_clk),
        .rise_sel (rise_sel),
        .strobe   (cap_stb)
    );

    sertx_slot_counter #(.SLOTS(SLOTS)) i_slots (
        .clk       (clk),
        .rst_n     (shdn_n),
        .slot_q    (slot_q),
        .slot_next (slot_next),
        .wrap      (slot_wrap)
    );

    // Holding register: written on every capture strobe.
    always_ff @(posedge clk or negedge shdn_n) begin
        if (!shdn_n) begin
            hold_q <= '0;
        end else if (cap_stb) begin
            hold_q <= pix_word;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge shdn_n) begin
        if (!shdn_n) begin
            state_q <= ST_WAIT_WORD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: T_CAPTURE_FIRST, T_FRAME_START, T_KEEP_STREAM.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_WORD: if (cap_stb)   state_d = ST_ARMED;
            ST_ARMED:     if (slot_wrap) state_d = ST_STREAM;
            ST_STREAM:                   state_d = ST_STREAM;
            default:                     state_d = ST_WAIT_WORD;
        endcase
    end

    // Outputs: frame transfer at the wrap, forwarded clock from the next slot.
    always_comb begin
        frame_load = slot_wrap && (state_q != ST_WAIT_WORD);
        fclk_d     = (state_d == ST_STREAM) && (slot_next < CNT_W'(HIGH_SLOTS));
    end

    always_ff @(posedge clk or negedge shdn_n) begin
        if (!shdn_n) begin
            fwd_clk <= 1'b0;
        end else begin
            fwd_clk <= fclk_d;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SLOTS-1:0] par;
        for (genvar t = 0; t < SLOTS; t++) begin : g_slot
            assign par[SLOTS-1-t] = hold_q[SRC_MAP[l][t]];
        end
        sertx_lane_shifter #(.SLOTS(SLOTS)) i_shift (
            .clk   (clk),
            .rst_n (shdn_n),
            .load  (frame_load),
            .par   (par),
            .ser   (lane_out[l])
        );
    end

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker
    import sertx_pkg::*;
(
    input logic              clk,
    input logic              shdn_n,
    input logic [WORD_W-1:0] pix_word,
    input logic [LANES-1:0]  lane_out,
    input logic              fwd_clk,
    input tx_state_t         state_q,
    input logic [CNT_W-1:0]  slot_q,
    input logic              slot_wrap,
    input logic              cap_stb,
    input logic [WORD_W-1:0] hold_q
);

    p_shutdown_quiet_r8: assert property (@(posedge clk)
        !shdn_n |-> (lane_out == '0) && !fwd_clk)
        else $error("R8 outputs not cleared in shutdown");

    p_capture_word_r1: assert property (@(posedge clk) disable iff (!shdn_n)
        cap_stb |=> hold_q == $past(pix_word))
        else $error("R1 captured word mismatch");

    p_hold_stable_r1: assert property (@(posedge clk) disable iff (!shdn_n)
        !cap_stb |=> $stable(hold_q))
        else $error("R1 hold changed without strobe");

    p_slot_wrap_r7: assert property (@(posedge clk) disable iff (!shdn_n)
        slot_wrap |=> slot_q == '0)
        else $error("R7 slot counter did not wrap");

    // First bit of each lane after a frame transfer (R2, R3, R4, R5).
    p_frame_head_r2: assert property (@(posedge clk) disable iff (!shdn_n)
        (slot_wrap && state_q != ST_WAIT_WORD) |=>
            (lane_out[0] == $past(hold_q[7]))  && (lane_out[1] == $past(hold_q[18])) &&
            (lane_out[2] == $past(hold_q[26])) && (lane_out[3] == $past(hold_q[23])))
        else $error("R2 frame head bits wrong");

    p_fwd_clk_shape_r6: assert property (@(posedge clk) disable iff (!shdn_n)
        $rose(fwd_clk) |=> fwd_clk ##1 fwd_clk ##1 fwd_clk ##1 !fwd_clk
                           ##1 !fwd_clk ##1 !fwd_clk ##1 fwd_clk)
        else $error("R6 forwarded clock shape wrong");

    p_quiet_before_stream_r9: assert property (@(posedge clk) disable iff (!shdn_n)
        (state_q != ST_STREAM) |-> (lane_out == '0) && !fwd_clk)
        else $error("R9 output active before first frame");

endmodule

bind sertx_pixel_serializer sertx_checker i_sertx_checker (
    .clk       (clk),
    .shdn_n    (shdn_n),
    .pix_word  (pix_word),
    .lane_out  (lane_out),
    .fwd_clk   (fwd_clk),
    .state_q   (state_q),
    .slot_q    (slot_q),
    .slot_wrap (slot_wrap),
    .cap_stb   (cap_stb),
    .hold_q    (hold_q)
);

// File: tb/test_sertx_pixel_serializer.sv
module test_sertx_pixel_serializer;

    localparam int NS = 7;
    localparam int NL = 4;
    // Transmit order per lane, from R2 to R5.
    localparam int TBL [NL][NS] = '{
        '{ 7,  6,  4,  3,  2,  1,  0},
        '{18, 15, 14, 13, 12,  9,  8},
        '{26, 25, 24, 22, 21, 20, 19},
        '{23, 17, 16, 11, 10,  5, 27}
    };

    logic        clk = 1'b0;
    logic        shdn_n;
    logic        pix_clk;
    logic        rise_sel;
    logic [27:0] pix_word;
    logic [3:0]  lane_out;
    logic        fwd_clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [27:0] exp_q[$];
    logic [27:0] last_word;
    bit          have_last;
    int          recv_cnt;
    int          idx = -1;
    logic        prev_fclk = 1'b0;
    bit          seen_frame = 1'b0;
    logic [27:0] acc;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    sertx_pixel_serializer i_sertx_pixel_serializer (
        .clk      (clk),
        .shdn_n   (shdn_n),
        .pix_clk  (pix_clk),
        .rise_sel (rise_sel),
        .pix_word (pix_word),
        .lane_out (lane_out),
        .fwd_clk  (fwd_clk)
    );

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL: %s", msg);
        end
    endtask

    // Deserializer: slot 0 is the cycle in which fwd_clk rises.
    always begin
        @(posedge clk);
        #1;
        if (!shdn_n) begin
            check(lane_out == 4'h0 && fwd_clk == 1'b0,
                  $sformatf("R8 in shutdown lanes=%h fwd=%b expected 0 0", lane_out, fwd_clk));
            idx        = -1;
            prev_fclk  = 1'b0;
            seen_frame = 1'b0;
        end else begin
            if (fwd_clk && !prev_fclk) begin
                if (idx >= 0)
                    check(1'b0, $sformatf("R6 clock rose at slot %0d expected slot 0", idx));
                idx        = 0;
                seen_frame = 1'b1;
                acc        = '0;
            end
            if (!seen_frame)
                check(lane_out == 4'h0 && !fwd_clk,
                      $sformatf("R9 before first frame lanes=%h fwd=%b expected 0 0", lane_out, fwd_clk));
            if (idx >= 0) begin
                for (int l = 0; l < NL; l++) acc[TBL[l][idx]] = lane_out[l];
                check(fwd_clk == (idx < 4),
                      $sformatf("R6 slot %0d fwd=%b expected %b", idx, fwd_clk, idx < 4));
                idx++;
                if (idx == NS) begin
                    idx = -1;
                    if (exp_q.size() > 0) begin
                        last_word = exp_q.pop_front();
                        have_last = 1'b1;
                        recv_cnt++;
                    end
                    check(have_last && acc == last_word,
                          $sformatf("R2 R3 R4 R5 R7 frame got %h expected %h", acc, last_word));
                end
            end
            prev_fclk = fwd_clk;
        end
    end

    // One pixel period: word valid before the selected edge (k=1),
    // complement placed before the opposite edge (k=5).
    task automatic pixel_period(input logic [27:0] w, input bit rmode);
        exp_q.push_back(w);
        for (int k = 0; k < NS; k++) begin
            @(negedge clk);
            if (k == 0) pix_word = w;
            if (k == 3) pix_word = ~w;
            pix_clk = rmode ? (k >= 1 && k <= 4) : !(k >= 1 && k <= 4);
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter_shutdown(input bit rmode);
        @(negedge clk);
        shdn_n = 1'b0;
        exp_q.delete();
        have_last = 1'b0;
        last_word = '0;
        recv_cnt  = 0;
        rise_sel  = rmode;
        pix_clk   = !rmode;
        #1;
        check(lane_out == 4'h0 && fwd_clk == 1'b0,
              $sformatf("R8 immediate clear lanes=%h fwd=%b expected 0 0", lane_out, fwd_clk));
        idle_cycles(4);
        shdn_n = 1'b1;
    endtask

    task automatic test_reset_state();
        idle_cycles(3);
        check(lane_out == 4'h0 && fwd_clk == 1'b0,
              $sformatf("R8 reset state lanes=%h fwd=%b expected 0 0", lane_out, fwd_clk));
    endtask

    // Walking one through every bit position, rising-edge capture.
    task automatic test_rising_walk();
        enter_shutdown(1'b1);
        idle_cycles(2);
        for (int b = 0; b < 28; b++) pixel_period(28'h1 << b, 1'b1);
        pixel_period(28'hFFF_FFFF, 1'b1);
        pixel_period(28'h555_5555, 1'b1);
        idle_cycles(3 * NS);
        check(exp_q.size() == 0 && recv_cnt == 30,
              $sformatf("R1 R7 rising: received %0d left %0d expected 30 0", recv_cnt, exp_q.size()));
    endtask

    // Pseudo-random words, falling-edge capture.
    task automatic test_falling_random();
        enter_shutdown(1'b0);
        idle_cycles(5);
        for (int i = 0; i < 20; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            pixel_period(seed[31:4], 1'b0);
        end
        idle_cycles(3 * NS);
        check(exp_q.size() == 0 && recv_cnt == 20,
              $sformatf("R1 R7 falling: received %0d left %0d expected 20 0", recv_cnt, exp_q.size()));
    endtask

    // Shutdown in mid-frame, long quiet release, then a fresh stream.
    task automatic test_midframe_shutdown();
        enter_shutdown(1'b1);
        idle_cycles(1);
        for (int i = 0; i < 4; i++) pixel_period(28'hA00_0000 | 28'(i), 1'b1);
        idle_cycles(3);
        enter_shutdown(1'b1);
        idle_cycles(20);
        check(lane_out == 4'h0 && fwd_clk == 1'b0,
              $sformatf("R9 quiet after release lanes=%h fwd=%b expected 0 0", lane_out, fwd_clk));
        pixel_period(28'h0C3_5A96, 1'b1);
        pixel_period(28'h93C_A5F0, 1'b1);
        pixel_period(28'h000_0000, 1'b1);
        pixel_period(28'hFED_CBA9, 1'b1);
        idle_cycles(3 * NS);
        check(exp_q.size() == 0 && recv_cnt == 4,
              $sformatf("R9 R7 restart: received %0d left %0d expected 4 0", recv_cnt, exp_q.size()));
    endtask

    initial begin
        shdn_n   = 1'b0;
        pix_clk  = 1'b0;
        rise_sel = 1'b1;
        pix_word = '0;
        have_last = 1'b0;
        last_word = '0;
        recv_cnt  = 0;
        test_reset_state();
        test_rising_walk();
        test_falling_random();
        test_midframe_shutdown();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL: watchdog expired before the scenarios ended");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule